// File: doc/BRIEF.md
# Misaligned Bus Access Splitter

This block sits between a processor's load/store path and a 64-bit big-endian data bus. It takes one request at a time, made of a byte address, an operand size (byte, half-word, word or double-word), a read/write flag and right-justified write data. It turns the request into one or two bus beats. For each beat it drives the beat's full byte address, a 4-bit transfer-size code and write data steered onto the byte lanes that the beat covers.

An operand that fits inside one 32-bit-aligned word goes out as a single beat, even when it is misaligned inside that word. An aligned double-word also goes out as a single beat. An operand that straddles a 32-bit word boundary is cut into two beats. The lower-address fragment goes first, and the second fragment starts at the next 32-bit-aligned address. On reads, the bytes returned in each acknowledged beat are collected into a right-justified result. A double-word request at an address that is not a multiple of eight is refused with an error pulse.

Top module: `mbus_split`

## Requirements
- R1: While and right after `rst` is high, `req_ready` is 1 and `bus_start`, `done` and `err` are 0.
- R2: `bus_tsize` carries the byte count of the beat: 1 byte = 0001, 2 = 0010, 3 = 0011, 4 = 0100, 8 = 0000. `req_size` is encoded 0 = byte, 1 = half-word, 2 = word, 3 = double-word.
- R3: Lane j (j = 0..7) is `bus_wdata[63-8j -: 8]`. A beat's first active lane is its address modulo 8. The lowest active lane of the whole access carries the most significant operand byte. The operand is the low 2^`req_size` bytes of `req_wdata`.
- R4: An access that stays inside one 32-bit-aligned word, or an aligned double-word, produces exactly one beat.
- R5: An access that crosses a 32-bit boundary produces two beats. The first is at the request address and carries 4 minus (address mod 4) bytes. The second is at the next 32-bit-aligned address and carries the remaining bytes.
- R6: Write lanes outside a beat are driven to zero. During reads `bus_wdata` is all zero.
- R7: After a read, `rdata` holds the operand right-justified with zero upper bytes. Lane j of the access maps back to the same operand byte as in R3, and lanes outside each beat are ignored. A write leaves `rdata` unchanged.
- R8: `bus_start` pulses for one cycle per beat. When the first beat of a split is acknowledged, the second `bus_start` appears in the next cycle. `done` pulses for one cycle, in the cycle after the last beat's `bus_ack`.
- R9: A double-word request with a nonzero address modulo 8 gives a one-cycle `err` in the next cycle and issues no beat and no `done`.
- R10: `req_ready` is low from the first beat until `done`. Requests and `bus_ack` seen while no beat is outstanding have no effect.
- R11: While a beat waits for `bus_ack`, `bus_addr`, `bus_tsize` and `bus_wdata` hold steady and `bus_start` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | DATA_W | Right-justified store data |
| done | output | 1 | Access finished |
| err | output | 1 | Request refused |
| rdata | output | DATA_W | Right-justified load result |
| bus_start | output | 1 | Beat start strobe |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_tsize | output | 4 | Beat transfer-size code |
| bus_wdata | output | DATA_W | Lane-steered store data |
| bus_ack | input | 1 | Beat acknowledge |
| bus_rdata | input | DATA_W | Lane data returned by the bus |

## Verification
The close case is the acknowledge of a split access's first beat. In that same cycle the block folds the first fragment's lanes into the read result and launches the second beat with new lanes, size and address. The bench provokes it by acknowledging with zero wait, in the very cycle the first strobe becomes visible. It also acknowledges after one- and two-cycle waits, across every size, offset and direction. The second beat's address, code and lanes are judged one cycle after the acknowledge. The merged result is judged at `done` against bytes computed from an arithmetic memory image. Because the model returns neighbouring bytes on unused lanes, a wrong lane choice shows up in the result.

// File: rtl/mbus_split_pkg.sv
package mbus_split_pkg;

  // operand size as presented on req_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } opsize_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } state_t;

endpackage

// File: rtl/mbus_split_plan.sv
// Works out how a request is cut into beats.
module mbus_split_plan
  import mbus_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LANES      = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int CNT_W  = OFF_W + 1,
  localparam int WOFF_W = $clog2(WORD_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [CNT_W-1:0]  nbytes,
  output logic [CNT_W-1:0]  cnt1,
  output logic [CNT_W-1:0]  cnt2,
  output logic              split,
  output logic              bad,
  output logic [ADDR_W-1:0] addr2
);

  logic [CNT_W:0] end_pos;

  always_comb begin
    nbytes  = CNT_W'(1) << size;
    end_pos = (CNT_W+1)'(addr[WOFF_W-1:0]) + (CNT_W+1)'(nbytes);
    bad     = (size == SZ_DBL) && (addr[OFF_W-1:0] != '0);
    split   = (size != SZ_DBL) && (end_pos > (CNT_W+1)'(WORD_BYTES));
    cnt1    = split ? (CNT_W'(WORD_BYTES) - CNT_W'(addr[WOFF_W-1:0])) : nbytes;
    cnt2    = nbytes - cnt1;
    addr2   = {addr[ADDR_W-1:WOFF_W] + 1'b1, {WOFF_W{1'b0}}};
  end

endmodule

// File: rtl/mbus_split_wsteer.sv
// Places right-justified operand bytes onto big-endian lanes for one beat.
module mbus_split_wsteer #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [CNT_W-1:0]   first,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   nbytes,
  input  logic               wr_en,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] lanes
);

  always_comb begin
    int rel;
    int src;
    lanes = '0;
    rel   = 0;
    src   = 0;
    for (int j = 0; j < LANES; j++) begin
      rel = j - int'(off);
      if (wr_en && rel >= 0 && rel < int'(cnt)) begin
        src = int'(nbytes) - 1 - int'(first) - rel;
        if (src >= 0) lanes[8*(LANES-1-j) +: 8] = wdata[8*src +: 8];
      end
    end
  end

endmodule

// File: rtl/mbus_split_rmerge.sv
// Folds the active lanes of one acknowledged beat into the read result.
module mbus_split_rmerge #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [CNT_W-1:0]   first,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   nbytes,
  input  logic [8*LANES-1:0] lanes,
  input  logic [8*LANES-1:0] acc_in,
  output logic [8*LANES-1:0] acc_out
);

  always_comb begin
    int rel;
    int dst;
    acc_out = acc_in;
    rel     = 0;
    dst     = 0;
    for (int j = 0; j < LANES; j++) begin
      rel = j - int'(off);
      if (rel >= 0 && rel < int'(cnt)) begin
        dst = int'(nbytes) - 1 - int'(first) - rel;
        if (dst >= 0) acc_out[8*dst +: 8] = lanes[8*(LANES-1-j) +: 8];
      end
    end
  end

endmodule

// File: rtl/mbus_split.sv
module mbus_split
  import mbus_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_start,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_tsize,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;

  state_t             state;
  logic               two_q;
  logic [ADDR_W-1:0]  a2_q;
  logic [CNT_W-1:0]   c2_q, cur_cnt, cur_first, nb_q;
  logic [OFF_W-1:0]   cur_off;
  logic [DATA_W-1:0]  wd_q, acc_q;

  logic [CNT_W-1:0]   p_nb, p_c1, p_c2;
  logic               p_split, p_bad;
  logic [ADDR_W-1:0]  p_a2;

  logic               idle;
  logic [OFF_W-1:0]   s_off;
  logic [CNT_W-1:0]   s_first, s_cnt, s_nb;
  logic [DATA_W-1:0]  s_wd, s_lanes, m_acc;
  logic               s_we;

  assign idle      = (state == ST_IDLE);
  assign req_ready = idle;

  mbus_split_plan #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_BYTES(WORD_BYTES)) u_plan (
    .addr(req_addr), .size(req_size), .nbytes(p_nb), .cnt1(p_c1), .cnt2(p_c2),
    .split(p_split), .bad(p_bad), .addr2(p_a2)
  );

  // steering inputs: the new request when idle, the held second fragment otherwise
  assign s_off   = idle ? req_addr[OFF_W-1:0] : a2_q[OFF_W-1:0];
  assign s_first = idle ? '0 : cur_cnt;
  assign s_cnt   = idle ? p_c1 : c2_q;
  assign s_nb    = idle ? p_nb : nb_q;
  assign s_wd    = idle ? req_wdata : wd_q;
  assign s_we    = idle ? req_write : bus_write;

  mbus_split_wsteer #(.LANES(LANES)) u_wsteer (
    .off(s_off), .first(s_first), .cnt(s_cnt), .nbytes(s_nb),
    .wr_en(s_we), .wdata(s_wd), .lanes(s_lanes)
  );

  mbus_split_rmerge #(.LANES(LANES)) u_rmerge (
    .off(cur_off), .first(cur_first), .cnt(cur_cnt), .nbytes(nb_q),
    .lanes(bus_rdata), .acc_in(acc_q), .acc_out(m_acc)
  );

  // size code is the byte count modulo the lane count: a full-width beat reads as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      two_q     <= 1'b0;
      a2_q      <= '0;
      c2_q      <= '0;
      cur_cnt   <= '0;
      cur_first <= '0;
      cur_off   <= '0;
      nb_q      <= '0;
      wd_q      <= '0;
      acc_q     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
      bus_start <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_tsize <= '0;
      bus_wdata <= '0;
    end else begin
      bus_start <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (p_bad) begin
              err <= 1'b1;
            end else begin
              bus_start <= 1'b1;
              bus_write <= req_write;
              bus_addr  <= req_addr;
              bus_tsize <= 4'(p_c1[OFF_W-1:0]);
              bus_wdata <= s_lanes;
              cur_off   <= req_addr[OFF_W-1:0];
              cur_first <= '0;
              cur_cnt   <= p_c1;
              nb_q      <= p_nb;
              two_q     <= p_split;
              a2_q      <= p_a2;
              c2_q      <= p_c2;
              wd_q      <= req_wdata;
              acc_q     <= '0;
              state     <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (bus_ack) begin
            acc_q <= m_acc;
            if (two_q) begin
              bus_start <= 1'b1;
              bus_addr  <= a2_q;
              bus_tsize <= 4'(c2_q[OFF_W-1:0]);
              bus_wdata <= s_lanes;
              cur_off   <= a2_q[OFF_W-1:0];
              cur_first <= cur_cnt;
              cur_cnt   <= c2_q;
              state     <= ST_SECOND;
            end else begin
              done  <= 1'b1;
              if (!bus_write) rdata <= m_acc;
              state <= ST_IDLE;
            end
          end
        end
        ST_SECOND: begin
          if (bus_ack) begin
            acc_q <= m_acc;
            done  <= 1'b1;
            if (!bus_write) rdata <= m_acc;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbus_split_chk.sv
module mbus_split_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              done,
  input logic              err,
  input logic              bus_start,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_tsize,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);

  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(WORD_BYTES);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (req_ready && !bus_start && !done && !err));

  a_r2_tsize_legal: assert property (@(posedge clk) disable iff (rst)
    bus_start |-> (bus_tsize <= 4'd4));

  a_r5_second_beat_aligned: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !$past(req_ready)) |-> (bus_addr[WOFF_W-1:0] == '0));

  a_r6_read_lanes_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !bus_write) |-> (bus_wdata == '0));

  a_r8_done_follows_ack: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_ack));

  a_r9_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size == 2'd3 && req_addr[OFF_W-1:0] != '0)
      |=> (err && !bus_start));

  a_r9_err_without_beat: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_start && !done));

  a_r10_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    bus_start |-> !req_ready);

  a_r11_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !bus_ack) |=>
      ($stable(bus_addr) && $stable(bus_tsize) && $stable(bus_wdata) && !bus_start));

endmodule

bind mbus_split mbus_split_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_addr(req_addr), .done(done), .err(err),
  .bus_start(bus_start), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_tsize(bus_tsize), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/mbus_split_tb.sv
module mbus_split_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        done, err;
  logic [63:0] rdata;
  logic        bus_start, bus_write;
  logic [31:0] bus_addr;
  logic [3:0]  bus_tsize;
  logic [63:0] bus_wdata;
  logic        bus_ack;
  logic [63:0] bus_rdata;

  int total  = 0;
  int failed = 0;
  logic [63:0] last_rd = '0;

  always #(CLK_P/2) clk = ~clk;

  mbus_split u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .bus_start(bus_start), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_tsize(bus_tsize), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [7:0] t;
    t = a[7:0];
    return t * 8'd37 + 8'd11;
  endfunction

  function automatic logic [63:0] bus_model(input logic [31:0] a);
    logic [63:0] r;
    r = '0;
    for (int j = 0; j < 8; j++) r[8*(7-j) +: 8] = mem_byte({a[31:3], 3'b000} + 32'(j));
    return r;
  endfunction

  function automatic logic [63:0] exp_lanes(input int off, input int first, input int cnt,
                                            input int n, input logic [63:0] wd);
    logic [63:0] r;
    r = '0;
    for (int j = 0; j < 8; j++)
      if (j >= off && j < off + cnt) r[8*(7-j) +: 8] = wd[8*(n-1-(first+j-off)) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] exp_read(input logic [31:0] a, input int n);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[8*(n-1-i) +: 8] = mem_byte(a + 32'(i));
    return r;
  endfunction

  function automatic logic [3:0] tcode(input int c);
    return (c == 8) ? 4'd0 : 4'(c);
  endfunction

  // wait lat cycles (with a stray request on the first), then acknowledge
  task automatic serve(input int lat);
    logic [31:0] hold;
    hold = bus_addr;
    for (int k = 0; k < lat; k++) begin
      if (k == 0) begin
        req_valid = 1'b1;
        req_size  = 2'd0;
        req_addr  = 32'hFFFF_FFF0;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(!bus_start && !done && bus_addr == hold,
          "R11/R10 beat held, stray request ignored", bus_addr, hold);
    end
    bus_ack   = 1'b1;
    bus_rdata = bus_model(bus_addr);
    @(negedge clk);
    bus_ack   = 1'b0;
    bus_rdata = 64'hA5A5_5A5A_C3C3_3C3C;
  endtask

  task automatic run_req(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                         input logic [63:0] wd, input int lat);
    int n, off, c1, c2;
    logic bad, split;
    logic [31:0] a2;
    logic [63:0] e1, e2, er;
    n     = 1 << sz;
    off   = int'(a[2:0]);
    bad   = (sz == 2'd3) && (off != 0);
    split = (sz != 2'd3) && ((int'(a[1:0]) + n) > 4);
    c1    = split ? 4 - int'(a[1:0]) : n;
    c2    = n - c1;
    a2    = {a[31:2] + 30'd1, 2'b00};
    e1    = wr ? exp_lanes(off, 0, c1, n, wd) : 64'd0;
    e2    = wr ? exp_lanes(int'(a2[2:0]), c1, c2, n, wd) : 64'd0;
    er    = wr ? last_rd : exp_read(a, n);

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(err && !bus_start && !done, "R9 refused without beat", {61'd0, err, bus_start, done}, 64'd4);
      @(negedge clk);
      chk(!err && !bus_start && !done && req_ready, "R9 no later activity",
          {60'd0, err, bus_start, done, req_ready}, 64'd1);
      return;
    end
    chk(bus_start && !req_ready, "R10 busy with first beat", {62'd0, bus_start, req_ready}, 64'd2);
    chk(bus_addr == a, "R5 first beat address", bus_addr, a);
    chk(bus_tsize == tcode(c1), "R2 first beat size code", bus_tsize, tcode(c1));
    chk(bus_wdata == e1, wr ? "R3 first beat lanes" : "R6 read drives zero lanes", bus_wdata, e1);
    serve(lat);
    if (split) begin
      chk(bus_start && !done, "R8 second beat one cycle after first ack", {62'd0, bus_start, done}, 64'd2);
      chk(bus_addr == a2, "R5 second beat address", bus_addr, a2);
      chk(bus_tsize == tcode(c2), "R2 second beat size code", bus_tsize, tcode(c2));
      chk(bus_wdata == e2, wr ? "R3/R6 second beat lanes" : "R6 read drives zero lanes", bus_wdata, e2);
      serve((lat + 1) % 3);
    end else begin
      chk(!bus_start, "R4 single beat only", {63'd0, bus_start}, 64'd0);
    end
    chk(done, "R8 done after last ack", {63'd0, done}, 64'd1);
    chk(rdata == er, "R7 merged right-justified result", rdata, er);
    if (!wr) last_rd = er;
    @(negedge clk);
    chk(!done && !bus_start && req_ready, "R8/R10 done is one cycle, back to idle",
        {61'd0, done, bus_start, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; bus_ack = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_start && !done && !err, "R1 reset state",
        {60'd0, req_ready, bus_start, done, err}, 64'd8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !bus_start && !done && !err, "R1 state after reset",
        {60'd0, req_ready, bus_start, done, err}, 64'd8);

    // acknowledge with nothing outstanding
    bus_ack = 1'b1;
    bus_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    bus_ack = 1'b0;
    @(negedge clk);
    chk(!done && !bus_start && req_ready && rdata == 64'd0, "R10 idle ack ignored", rdata, 64'd0);

    for (int rw = 0; rw < 2; rw++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++) begin
          logic [31:0] a;
          logic [63:0] wd;
          a  = 32'h0000_1000 + 32'(16 * sz + 64 * rw + off);
          wd = 64'hF1E2_D3C4_B5A6_9788 ^ ({32'd0, a} * 64'h0101_0101_0101_0101);
          run_req(rw[0], sz[1:0], a, wd, (off + sz) % 3);
        end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule